// File: doc/BRIEF.md
# Integer Execute Unit with Overflow Trap

This block is the integer arithmetic and logic stage of a 32-bit load/store core. Each cycle it can accept one instruction word and the two source register values that the register file has already read for it. From the instruction it works out the operation, the second operand and the destination register. One cycle later it presents the result, a destination index, a register-write strobe and an overflow-trap flag. The strobe and the index go to the register file. The trap flag goes to the exception logic.

Two families of operation are handled. The additive family comes in a trapping form and a silent form: the trapping form raises the trap on signed overflow and withholds the register write, while the silent form writes the wrapped result. The bitwise family (AND, OR, XOR) works with a register or an immediate second operand. Immediates for additive instructions are sign-extended, and immediates for bitwise instructions are zero-extended.

Top module: `alu_exec`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset is released, `out_valid`, `wr_en` and `ovf_trap` are 0.
- R2: Outputs appear on the clock edge after the instruction is presented. The opcode field is instr[31:26], and opcode 0 marks a register-form word. In a register-form word the destination is instr[15:11] and the function code is instr[5:0]. In any other word the destination is instr[20:16] and the immediate is instr[15:0]. `wr_idx` carries that destination.
- R3: Function codes 0x20 (add) and 0x22 (subtract, rs minus rt) produce the wrapped result in `result`. When the signed result overflows 32 bits, `ovf_trap` is 1 and `wr_en` is 0.
- R4: Function codes 0x21 (add) and 0x23 (subtract) write the wrapped result and never raise `ovf_trap`.
- R5: Function codes 0x24, 0x25 and 0x26 write rs AND rt, rs OR rt and rs XOR rt respectively, without a trap.
- R6: Opcodes 8 and 9 add rs to the sign-extended immediate. Opcode 8 traps on signed overflow, with `wr_en` forced to 0. Opcode 9 never traps.
- R7: Opcodes 12, 13 and 14 write rs AND, OR and XOR the zero-extended immediate respectively, without a trap.
- R8: A destination of register 0 gives `wr_en` = 0. Trapping is unaffected.
- R9: Any other opcode, or any other function code under opcode 0, gives `wr_en` = 0, `ovf_trap` = 0 and `result` = 0.
- R10: When `in_valid` is 0, the next cycle has `out_valid`, `wr_en` and `ovf_trap` at 0 and `result` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands are present this cycle |
| instr | input | 32 | Instruction word |
| rs_data | input | DATA_W | First source register value |
| rt_data | input | DATA_W | Second source register value |
| out_valid | output | 1 | Registered copy of in_valid |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 5 | Destination register index |
| result | output | DATA_W | Computed value |
| ovf_trap | output | 1 | Signed overflow trap raised |

## Verification
The bench builds the unit with its default parameters: a 32-bit data path and a 16-bit immediate. At this width the exact overflow boundaries can be driven: 0x7FFFFFFF plus one, the most negative value minus one, and an immediate of 0xFFFF that acts as minus one for additive instructions but as 65535 for bitwise ones. A behavioural model, built on 64-bit integers, predicts every output one cycle later. The model is fed directed corner cases and then a random mix of supported and unsupported encodings, including register-0 destinations and idle cycles.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int OPC_HI   = 31;
    localparam int OPC_LO   = 26;
    localparam int RT_HI    = 20;
    localparam int RT_LO    = 16;
    localparam int RD_HI    = 15;
    localparam int RD_LO    = 11;
    localparam int FN_HI    = 5;
    localparam int FN_LO    = 0;
    localparam int REG_IDXW = 5;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ADD,
        OP_SUB,
        OP_AND,
        OP_OR,
        OP_XOR
    } alu_op_e;

    typedef struct packed {
        alu_op_e               op;
        logic                  trap_en;
        logic                  use_imm;
        logic                  sext;
        logic [REG_IDXW-1:0]   dst;
    } dec_s;
endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
(
    input  logic [31:0] instr,
    output dec_s        dec
);
    logic [5:0] opc;
    logic [5:0] fn;

    always_comb begin
        opc         = instr[OPC_HI:OPC_LO];
        fn          = instr[FN_HI:FN_LO];
        dec.op      = OP_NONE;
        dec.trap_en = 1'b0;
        dec.use_imm = 1'b0;
        dec.sext    = 1'b0;
        dec.dst     = instr[RT_HI:RT_LO];
        if (opc == 6'd0) begin
            dec.dst = instr[RD_HI:RD_LO];
            unique case (fn)
                6'h20: begin dec.op = OP_ADD; dec.trap_en = 1'b1; end
                6'h21: dec.op = OP_ADD;
                6'h22: begin dec.op = OP_SUB; dec.trap_en = 1'b1; end
                6'h23: dec.op = OP_SUB;
                6'h24: dec.op = OP_AND;
                6'h25: dec.op = OP_OR;
                6'h26: dec.op = OP_XOR;
                default: dec.op = OP_NONE;
            endcase
        end else begin
            dec.use_imm = 1'b1;
            unique case (opc)
                6'd8:  begin dec.op = OP_ADD; dec.sext = 1'b1; dec.trap_en = 1'b1; end
                6'd9:  begin dec.op = OP_ADD; dec.sext = 1'b1; end
                6'd12: dec.op = OP_AND;
                6'd13: dec.op = OP_OR;
                6'd14: dec.op = OP_XOR;
                default: dec.op = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/alu_operand.sv
module alu_operand #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [IMM_W-1:0]  imm,
    input  logic              sext,
    input  logic              use_imm,
    input  logic [DATA_W-1:0] rt_data,
    output logic [DATA_W-1:0] opb
);
    localparam int PAD_W = DATA_W - IMM_W;
    logic [DATA_W-1:0] imm_ext;

    generate
        if (PAD_W > 0) begin : g_pad
            always_comb imm_ext = {{PAD_W{sext & imm[IMM_W-1]}}, imm};
        end else begin : g_nopad
            always_comb imm_ext = imm[DATA_W-1:0];
        end
    endgenerate

    always_comb opb = use_imm ? imm_ext : rt_data;
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res,
    output logic              ovf
);
    localparam int MSB = DATA_W - 1;
    logic              sub;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] sum;

    always_comb begin
        sub   = (op == OP_SUB);
        b_eff = sub ? ~b : b;
        sum   = a + b_eff + {{(DATA_W-1){1'b0}}, sub};
        ovf   = 1'b0;
        res   = '0;
        unique case (op)
            OP_ADD, OP_SUB: begin
                res = sum;
                ovf = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
            end
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu_exec.sv
module alu_exec
    import alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [31:0]         instr,
    input  logic [DATA_W-1:0]   rs_data,
    input  logic [DATA_W-1:0]   rt_data,
    output logic                out_valid,
    output logic                wr_en,
    output logic [REG_IDXW-1:0] wr_idx,
    output logic [DATA_W-1:0]   result,
    output logic                ovf_trap
);
    typedef struct packed {
        logic                vld;
        logic                we;
        logic                ovf;
        logic [REG_IDXW-1:0] idx;
        logic [DATA_W-1:0]   res;
    } stage_s;

    dec_s              dec;
    logic [DATA_W-1:0] opb;
    logic [DATA_W-1:0] alu_res;
    logic              alu_ovf;
    stage_s            st_d;
    stage_s            st_q;

    alu_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    alu_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opb (
        .imm     (instr[IMM_W-1:0]),
        .sext    (dec.sext),
        .use_imm (dec.use_imm),
        .rt_data (rt_data),
        .opb     (opb)
    );

    alu_core #(.DATA_W(DATA_W)) u_core (
        .op  (dec.op),
        .a   (rs_data),
        .b   (opb),
        .res (alu_res),
        .ovf (alu_ovf)
    );

    always_comb begin
        st_d = '0;
        if (in_valid) begin
            st_d.vld = 1'b1;
            st_d.ovf = dec.trap_en & alu_ovf;
            st_d.idx = dec.dst;
            st_d.res = alu_res;
            st_d.we  = (dec.op != OP_NONE) && !st_d.ovf && (dec.dst != '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign wr_en     = st_q.we;
    assign wr_idx    = st_q.idx;
    assign result    = st_q.res;
    assign ovf_trap  = st_q.ovf;
endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [31:0]       instr,
    input logic              out_valid,
    input logic              wr_en,
    input logic [4:0]        wr_idx,
    input logic [DATA_W-1:0] result,
    input logic              ovf_trap
);
    assert_trap_blocks_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap |-> !wr_en);

    assert_silent_add_no_trap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[31:26] == 6'd0 && (instr[5:0] == 6'h21 || instr[5:0] == 6'h23))
        |=> !ovf_trap);

    assert_logic_imm_no_trap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (instr[31:26] == 6'd12 || instr[31:26] == 6'd13 || instr[31:26] == 6'd14))
        |=> !ovf_trap);

    assert_no_zero_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx != 5'd0));

    assert_unsupported_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[31:26] == 6'd4) |=> (!wr_en && !ovf_trap && result == '0));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !wr_en && !ovf_trap));

    assert_flags_need_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || ovf_trap) |-> out_valid);
endmodule

bind alu_exec alu_exec_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .instr     (instr),
    .out_valid (out_valid),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .result    (result),
    .ovf_trap  (ovf_trap)
);

// File: tb/alu_exec_bench.sv
module alu_exec_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs_data = '0;
    logic [31:0] rt_data = '0;
    logic        out_valid;
    logic        wr_en;
    logic [4:0]  wr_idx;
    logic [31:0] result;
    logic        ovf_trap;

    int n_chk = 0;
    int n_fail = 0;

    logic        e_vld, e_we, e_ovf;
    logic [4:0]  e_idx;
    logic [31:0] e_res;
    string       e_tag;

    always #5 clk = ~clk;

    alu_exec u_alu_exec (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .rs_data(rs_data), .rt_data(rt_data), .out_valid(out_valid),
        .wr_en(wr_en), .wr_idx(wr_idx), .result(result), .ovf_trap(ovf_trap)
    );

    function automatic logic [31:0] rt_word(int rd, int fn);
        return {6'd0, 5'd1, 5'd2, rd[4:0], 5'd0, fn[5:0]};
    endfunction

    function automatic logic [31:0] it_word(int op, int rt, int imm);
        return {op[5:0], 5'd1, rt[4:0], imm[15:0]};
    endfunction

    // Behavioural reference: 64-bit integers for overflow detection.
    task automatic model(input logic v, input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
        longint sa, sb, s;
        int op, fn;
        logic [31:0] bb;
        logic known, trap_en, is_sub;
        e_vld = v; e_we = 0; e_ovf = 0; e_idx = 0; e_res = 0;
        if (!v) begin e_tag = "R10"; return; end
        op = int'(w[31:26]); fn = int'(w[5:0]);
        known = 1; trap_en = 0; is_sub = 0; bb = b;
        if (op == 0) begin
            e_idx = w[15:11];
            case (fn)
                32: begin trap_en = 1; e_tag = "R3"; end
                34: begin trap_en = 1; is_sub = 1; e_tag = "R3"; end
                33: e_tag = "R4";
                35: begin is_sub = 1; e_tag = "R4"; end
                36: begin e_res = a & b; e_tag = "R5"; end
                37: begin e_res = a | b; e_tag = "R5"; end
                38: begin e_res = a ^ b; e_tag = "R5"; end
                default: begin known = 0; e_tag = "R9"; end
            endcase
        end else begin
            e_idx = w[20:16];
            case (op)
                8:  begin bb = {{16{w[15]}}, w[15:0]}; trap_en = 1; e_tag = "R6"; end
                9:  begin bb = {{16{w[15]}}, w[15:0]}; e_tag = "R6"; end
                12: begin e_res = a & {16'd0, w[15:0]}; e_tag = "R7"; end
                13: begin e_res = a | {16'd0, w[15:0]}; e_tag = "R7"; end
                14: begin e_res = a ^ {16'd0, w[15:0]}; e_tag = "R7"; end
                default: begin known = 0; e_tag = "R9"; end
            endcase
        end
        if (!known) begin e_res = 0; return; end
        if ((op == 0 && fn <= 35) || op == 8 || op == 9) begin
            sa = longint'($signed(a)); sb = longint'($signed(bb));
            s = is_sub ? sa - sb : sa + sb;
            e_res = is_sub ? a - bb : a + bb;
            e_ovf = trap_en && (s > 64'sd2147483647 || s < -64'sd2147483648);
        end
        e_we = !e_ovf;
        if (e_idx == 0) begin
            e_we = 0;
            if (!e_ovf) e_tag = "R8";
        end
    endtask

    task automatic compare();
        n_chk++;
        if ({out_valid, wr_en, ovf_trap, result} !== {e_vld, e_we, e_ovf, e_res}) begin
            n_fail++;
            $display("FAIL %s: vld/we/ovf/res got %b%b%b %h exp %b%b%b %h",
                     e_tag, out_valid, wr_en, ovf_trap, result, e_vld, e_we, e_ovf, e_res);
        end
        if (e_we) begin
            n_chk++;
            if (wr_idx !== e_idx) begin
                n_fail++;
                $display("FAIL R2: wr_idx got %0d exp %0d", wr_idx, e_idx);
            end
        end
    endtask

    // Present one input at a negedge; its outputs are compared at the next negedge.
    task automatic step(input logic v, input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
        in_valid = v; instr = w; rs_data = a; rt_data = b;
        model(v, w, a, b);
        @(negedge clk);
        compare();
    endtask

    initial begin
        #2000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: run hung, got timeout exp completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        in_valid = 1; instr = rt_word(3, 32); rs_data = 1; rt_data = 2;
        @(negedge clk);
        n_chk++;
        if ({out_valid, wr_en, ovf_trap} !== 3'b000) begin
            n_fail++;
            $display("FAIL R1: flags got %b%b%b exp 000", out_valid, wr_en, ovf_trap);
        end
        in_valid = 0;
        @(negedge clk);
        rst_n = 1;
        n_chk++;
        if ({out_valid, wr_en, ovf_trap} !== 3'b000) begin
            n_fail++;
            $display("FAIL R1: flags after release got %b%b%b exp 000", out_valid, wr_en, ovf_trap);
        end
        // R3 trapping add/sub
        step(1, rt_word(8, 32), 32'h3fff_0000, 32'h0000_1234);
        step(1, rt_word(8, 32), 32'h7fff_ffff, 32'h7fff_ffff);
        step(1, rt_word(9, 34), 32'h7fff_ffff, 32'h8000_0001);
        step(1, rt_word(9, 34), 32'h8000_0000, 32'h0000_0001);
        step(1, rt_word(9, 34), 32'h0000_0005, 32'h0000_0009);
        // R4 silent forms wrap
        step(1, rt_word(10, 33), 32'h7fff_ffff, 32'h0000_0001);
        step(1, rt_word(10, 35), 32'h0000_0000, 32'h0000_0001);
        // R5 register bitwise
        step(1, rt_word(11, 36), 32'hf0f0_1234, 32'hff00_ff00);
        step(1, rt_word(12, 37), 32'hf0f0_1234, 32'h0f00_000f);
        step(1, rt_word(13, 38), 32'haaaa_5555, 32'hffff_0000);
        // R6 additive immediate, sign-extended
        step(1, it_word(8, 7, 16'hffff), 32'd5, 32'hdead_beef);
        step(1, it_word(8, 7, 16'h0001), 32'h7fff_ffff, 32'd0);
        step(1, it_word(9, 7, 16'h0001), 32'h7fff_ffff, 32'd0);
        step(1, it_word(8, 7, 16'h8000), 32'h8000_0000, 32'd0);
        // R7 bitwise immediate, zero-extended
        step(1, it_word(12, 6, 16'h8000), 32'hffff_ffff, 32'd0);
        step(1, it_word(13, 6, 16'hffff), 32'h1200_0000, 32'd0);
        step(1, it_word(14, 6, 16'h8001), 32'hffff_ffff, 32'd0);
        // R8 register 0 destination
        step(1, rt_word(0, 33), 32'd4, 32'd5);
        step(1, it_word(13, 0, 16'h0f0f), 32'd0, 32'd0);
        step(1, rt_word(0, 32), 32'h7fff_ffff, 32'h7fff_ffff);
        // R9 unsupported encodings
        step(1, rt_word(5, 39), 32'd1, 32'd2);
        step(1, it_word(4, 5, 16'h0003), 32'd1, 32'd2);
        step(1, it_word(10, 5, 16'h0003), 32'd1, 32'd2);
        // R10 idle cycle
        step(0, rt_word(5, 33), 32'd1, 32'd2);
        // Random mix
        for (int i = 0; i < 400; i++) begin
            int sel;
            logic [31:0] w, a, b;
            sel = int'($urandom_range(0, 13));
            a = $urandom; b = $urandom;
            if ($urandom_range(0, 3) == 0) a = {a[31], {31{~a[31]}}};
            case (sel)
                0, 1, 2, 3, 4, 5, 6: w = rt_word(int'($urandom_range(0, 31)), 32 + sel);
                7:  w = rt_word(int'($urandom_range(0, 31)), int'($urandom_range(0, 63)));
                8:  w = it_word(8,  int'($urandom_range(0, 31)), int'($urandom_range(0, 65535)));
                9:  w = it_word(9,  int'($urandom_range(0, 31)), int'($urandom_range(0, 65535)));
                10: w = it_word(12, int'($urandom_range(0, 31)), int'($urandom_range(0, 65535)));
                11: w = it_word(13, int'($urandom_range(0, 31)), int'($urandom_range(0, 65535)));
                12: w = it_word(14, int'($urandom_range(0, 31)), int'($urandom_range(0, 65535)));
                default: w = $urandom;
            endcase
            step(($urandom_range(0, 7) != 0), w, a, b);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule